// File: doc/BRIEF.md
# Dual-Modulus Swallow Counter

This block sits behind an external two-modulus prescaler (ratios P and P+1) and turns it into a programmable divider with total ratio N = M·P + A. It is clocked by the prescaler output. Each count cycle lasts M prescaler pulses. For the first A pulses the modulus control output `mc` is held low, so the prescaler divides by P+1. For the remaining M−A pulses `mc` is high, so the prescaler divides by P. When the cycle completes, the block emits a one-clock feedback pulse `fv` and starts a new cycle.

The programmed values `a_prog` and `m_prog` are taken into working registers only at the start of a cycle. A cycle starts on the first clock after reset, after a completed cycle, or when `resync` is high. Values of M below 8 are raised to 8. A cycle whose M is not greater than A is flagged on `range_err`.

The control is a three-state machine:
- `ST_IDLE` is the state after reset.
- `ST_SWALLOW` holds `mc` low.
- `ST_MAIN` holds `mc` high.

The transitions are:
- *start*: IDLE to SWALLOW, or to MAIN when the new A is 0.
- *swallow-done*: SWALLOW to MAIN once A pulses have been counted.
- *wrap*: SWALLOW or MAIN back to the start state when the position reaches M−1.
- *resync*: any state to the start state.

Top module: `swallow_counter`

## Requirements
- R1: While `rst_n` is low, `mc`, `fv` and `range_err` are all 0. The first rising clock edge after reset is released starts a cycle at position 0.
- R2: Within a cycle, `mc` is 0 for the first A clocks (positions 0 to A−1) and 1 for the remaining M−A clocks.
- R3: A cycle lasts exactly M clocks. `fv` is 1 for exactly one clock, at position 0 of every cycle that follows a completed cycle, so its period is M clocks.
- R4: When A = 0, `mc` is 1 from position 0 through the whole cycle.
- R5: An `m_prog` value below 8 is used as 8. Every A value from 0 to 127 is legal as given.
- R6: `range_err` is 1 for every cycle whose loaded M is less than or equal to its loaded A. During such a cycle, `mc` stays 0 throughout.
- R7: A clock edge with `resync` high starts a new cycle at position 0 with freshly loaded values, and `fv` stays 0 on that cycle's first clock.
- R8: Changes to `a_prog` or `m_prog` in the middle of a cycle do not affect that cycle. They take effect at the next cycle start.
- R9: The extreme settings A = 127 and M = 1023 obey R2 and R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fin_clk | input | 1 | Prescaler output clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| resync | input | 1 | Restart the count cycle on this edge |
| a_prog | input | 7 | Swallow count A |
| m_prog | input | 10 | Main count M |
| mc | output | 1 | Modulus control: 0 selects P+1, 1 selects P |
| fv | output | 1 | One-clock pulse per completed cycle |
| range_err | output | 1 | Current cycle has M not greater than A |

## Verification
The bench builds the block with its default widths: a 7-bit A, a 10-bit M and a floor of 8 on M. With these widths, a full-scale cycle (A = 127, M = 1023) fits in about a thousand clocks, so the bench runs it in full. The same widths put the clamped floor cycle of 8 clocks and the A = M−1 and M ≤ A corners within a few dozen clocks. Every clock is compared against a position-based model built from R2 and R3, and the `fv` spacing is measured directly.

// File: rtl/swallow_pkg.sv
`timescale 1ns/1ps
package swallow_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } swl_state_e;
endpackage

// File: rtl/swallow_prog.sv
`timescale 1ns/1ps
// Loads and clamps the programmed ratios at each cycle start.
module swallow_prog #(
    parameter int A_W   = 7,
    parameter int M_W   = 10,
    parameter int M_MIN = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [A_W-1:0] a_in,
    input  logic [M_W-1:0] m_in,
    output logic [A_W-1:0] a_cur,
    output logic [M_W-1:0] m_cur,
    output logic           range_err
);
    localparam int CMP_W = (A_W > M_W) ? A_W : M_W;
    localparam logic [M_W-1:0] M_FLOOR = M_W'(M_MIN);

    logic [M_W-1:0] m_clamped;
    logic           err_new;

    always_comb begin
        m_clamped = (m_in < M_FLOOR) ? M_FLOOR : m_in;
        err_new   = (CMP_W'(a_in) >= CMP_W'(m_clamped));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_cur     <= '0;
            m_cur     <= M_FLOOR;
            range_err <= 1'b0;
        end else if (load) begin
            a_cur     <= a_in;
            m_cur     <= m_clamped;
            range_err <= err_new;
        end
    end

    // R5
    m_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_cur >= M_FLOOR);
endmodule

// File: rtl/swallow_fsm.sv
`timescale 1ns/1ps
// Position counter and modulus-control state machine.
module swallow_fsm
    import swallow_pkg::*;
#(
    parameter int A_W = 7,
    parameter int M_W = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           resync,
    input  logic           a_new_zero,
    input  logic [A_W-1:0] a_cur,
    input  logic [M_W-1:0] m_cur,
    output logic           load,
    output logic           mc_o,
    output logic           fv_o
);
    swl_state_e     state, state_n, start_st;
    logic [M_W-1:0] pos, pos_plus;
    logic           last, restart, fv_q;

    always_comb begin
        pos_plus = pos + 1'b1;
        last     = (pos == m_cur - 1'b1);
        restart  = (state == ST_IDLE) || resync || last;
        start_st = a_new_zero ? ST_MAIN : ST_SWALLOW;
        load     = restart;
        state_n  = state;
        unique case (state)
            ST_IDLE:    state_n = start_st;
            ST_SWALLOW: begin
                if (restart)                     state_n = start_st;
                else if (pos_plus == M_W'(a_cur)) state_n = ST_MAIN;
                else                              state_n = ST_SWALLOW;
            end
            ST_MAIN:    state_n = restart ? start_st : ST_MAIN;
            default:    state_n = ST_IDLE;
        endcase
    end

    // state register and cycle position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pos   <= '0;
        end else begin
            state <= state_n;
            pos   <= restart ? '0 : pos_plus;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fv_q <= 1'b0;
        else        fv_q <= last && !resync && (state != ST_IDLE);
    end

    always_comb begin
        mc_o = (state == ST_MAIN);
        fv_o = fv_q;
    end

    // R2
    mc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mc_o) && pos != '0) |-> (pos == M_W'(a_cur)));
    // R3
    fv_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fv_o |-> (pos == '0 && state != ST_IDLE));
    // R3
    pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (pos < m_cur));
    // R7
    resync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> (pos == '0 && !fv_o));
endmodule

// File: rtl/swallow_counter.sv
`timescale 1ns/1ps
module swallow_counter #(
    parameter int A_W   = 7,
    parameter int M_W   = 10,
    parameter int M_MIN = 8
) (
    input  logic           fin_clk,
    input  logic           rst_n,
    input  logic           resync,
    input  logic [A_W-1:0] a_prog,
    input  logic [M_W-1:0] m_prog,
    output logic           mc,
    output logic           fv,
    output logic           range_err
);
    logic           load;
    logic [A_W-1:0] a_cur;
    logic [M_W-1:0] m_cur;

    swallow_prog #(.A_W(A_W), .M_W(M_W), .M_MIN(M_MIN)) prog_i (
        .clk       (fin_clk),
        .rst_n     (rst_n),
        .load      (load),
        .a_in      (a_prog),
        .m_in      (m_prog),
        .a_cur     (a_cur),
        .m_cur     (m_cur),
        .range_err (range_err)
    );

    swallow_fsm #(.A_W(A_W), .M_W(M_W)) fsm_i (
        .clk        (fin_clk),
        .rst_n      (rst_n),
        .resync     (resync),
        .a_new_zero (a_prog == '0),
        .a_cur      (a_cur),
        .m_cur      (m_cur),
        .load       (load),
        .mc_o       (mc),
        .fv_o       (fv)
    );

    // R6
    err_mc_low_chk: assert property (@(posedge fin_clk) disable iff (!rst_n)
        range_err |-> !mc);
endmodule

// File: tb/swallow_counter_tb_top.sv
`timescale 1ns/1ps
module swallow_counter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       resync = 1'b0;
    logic [6:0] a_prog = '0;
    logic [9:0] m_prog = 10'd8;
    logic       mc, fv, range_err;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    int  p = 0, al = 0, ml = 8;
    bit  started = 1'b0;
    bit  mcx = 1'b0, fvx = 1'b0, errx = 1'b0;

    always #2.5 clk = ~clk;

    swallow_counter dut_i (
        .fin_clk(clk), .rst_n(rst_n), .resync(resync),
        .a_prog(a_prog), .m_prog(m_prog),
        .mc(mc), .fv(fv), .range_err(range_err)
    );

    task automatic check(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // one clock: model update at the edge, compare away from it
    task automatic step(string req);
        @(posedge clk);
        if (!started || resync || p == ml - 1) begin
            fvx = started && !resync;
            p = 0;
            al = int'(a_prog);
            ml = (m_prog < 10'd8) ? 8 : int'(m_prog);
            started = 1'b1;
        end else begin
            p++;
            fvx = 1'b0;
        end
        mcx  = (p >= al);
        errx = (ml <= al);
        @(negedge clk);
        check(req, "mc", mc, mcx);
        check(req, "fv", fv, fvx);
        check(req, "range_err", range_err, errx);
    endtask

    task automatic restart_with(string req, int a, int m);
        a_prog = 7'(a);
        m_prog = 10'(m);
        resync = 1'b1;
        step(req);
        resync = 1'b0;
    endtask

    // count clocks between two fv pulses
    task automatic measure_period(string req, int exp);
        int gap = 0;
        int guard = 0;
        while (fv !== 1'b1 && guard < 3000) begin step(req); guard++; end
        step(req);
        gap = 1;
        while (fv !== 1'b1 && gap < 3000) begin step(req); gap++; end
        n_chk++;
        if (gap != exp) begin
            n_fail++;
            $display("FAIL %s fv period actual=%0d expected=%0d", req, gap, exp);
        end
    endtask

    task automatic t_reset();
        // R1: outputs quiet in reset, first edge after release is position 0
        repeat (3) @(negedge clk);
        check("R1", "mc in reset", mc, 1'b0);
        check("R1", "fv in reset", fv, 1'b0);
        check("R1", "err in reset", range_err, 1'b0);
        a_prog = 7'd3;
        m_prog = 10'd10;
        rst_n = 1'b1;
        started = 1'b0;
        repeat (25) step("R1");
    endtask

    task automatic t_basic();
        // R2 and R3: A=5, M=12
        restart_with("R2", 5, 12);
        repeat (40) step("R2");
        measure_period("R3", 12);
        restart_with("R2", 11, 12);   // A = M-1: one high clock per cycle
        repeat (30) step("R2");
    endtask

    task automatic t_a_zero();
        restart_with("R4", 0, 9);
        repeat (25) step("R4");
        measure_period("R4", 9);
    endtask

    task automatic t_clamp();
        restart_with("R5", 2, 3);     // M=3 runs as 8
        repeat (20) step("R5");
        measure_period("R5", 8);
        restart_with("R5", 0, 0);     // M=0 runs as 8
        measure_period("R5", 8);
    endtask

    task automatic t_err();
        restart_with("R6", 20, 10);
        repeat (25) step("R6");
        restart_with("R6", 10, 10);
        repeat (25) step("R6");
        restart_with("R6", 4, 10);    // legal again, flag clears
        repeat (12) step("R6");
    endtask

    task automatic t_resync();
        restart_with("R7", 6, 15);
        repeat (4) step("R7");
        restart_with("R7", 6, 15);    // mid-cycle restart, no fv
        check("R7", "no fv on resync", fv, 1'b0);
        repeat (14) step("R7");
        restart_with("R7", 6, 15);    // resync on the wrap clock
        check("R7", "no fv on wrap resync", fv, 1'b0);
        repeat (20) step("R7");
    endtask

    task automatic t_update();
        restart_with("R8", 3, 10);
        repeat (4) step("R8");
        a_prog = 7'd7;                // ignored until next cycle
        m_prog = 10'd20;
        repeat (5) step("R8");
        repeat (45) step("R8");
        measure_period("R8", 20);
    endtask

    task automatic t_extreme();
        restart_with("R9", 127, 1023);
        repeat (1030) step("R9");
        measure_period("R9", 1023);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        t_reset();
        t_basic();
        t_a_zero();
        t_clamp();
        t_err();
        t_resync();
        t_update();
        t_extreme();
        report();
    end
endmodule